// File: doc/BRIEF.md
# Function Configuration State Controller

This block holds the lifecycle state of a single attached I/O function and carries out commands against it: attach, configure, enable, block, deconfigure, unplug and reset. Each accepted command produces a 4-bit response code one cycle later. The code depends on three things: the request length, whether the function ID matches, and the current state.

Transitions that the host has to learn about push availability events into a small outgoing FIFO. The FIFO keeps a pending flag raised while it holds at least one event, and the host pops events one at a time. An unplug on an active function (disabled, enabled or blocked) asks the guest to let go and starts a release timeout. If the guest has not settled the function by the time the timeout runs out, the block forces it down. Forcing it down means pulsing the deregistration strobes for active interrupt and translation resources, dropping to standby and reporting the change.

Top module: `fn_cfg_ctrl`

## Requirements
- R1: After reset the state output is reserved. The state encoding is 0 reserved, 1 standby, 2 disabled, 3 enabled, 4 blocked. The function ID output equals DEF_FID. The handle output has its enable bit (MSB) clear and FN_IDX in its low bits. No event is pending, the overflow flag is clear and both strobes are low.
- R2: A command presented with `cmd_valid_i` for one cycle gives `rsp_valid_o` high for exactly the next cycle. `rsp_code_o` carries 0 normal, 1 no-action, 2 insufficient-length, 3 not-recognized or 4 reserved-state.
- R3: Configure (op 0) and deconfigure (op 1) with a length below 16 return code 2 before any other check, and change no state.
- R4: Configure or deconfigure whose function ID differs from the held ID return code 3 and change no state.
- R5: Configure returns 4 in reserved. In standby it moves to disabled and returns 0. In any other state it returns 1.
- R6: Deconfigure returns 4 in reserved and 1 in standby. In any active state it does four things: it pulses `dereg_irq_o` and `dereg_xlat_o` for one cycle, each only if its active input is high; it clears the enable bit; it moves to standby; and it returns 0.
- R7: Attach (op 4) moves reserved to standby. Enable (op 5) moves disabled to enabled and sets the enable bit. Block (op 6) moves enabled to blocked. Each of these returns 0 when it moves and 1 otherwise. Op 7 returns 1.
- R8: Reset (op 3) returns 0 and leaves reserved and standby untouched. From an active state it clears the enable bit and moves to disabled.
- R9: Unplug (op 2) in an active state returns 0, pushes event code 1 and restarts the release timer. RELEASE_CYC cycles after the command, the block deregisters active resources, clears the enable bit, moves to standby and pushes event code 2.
- R10: Unplug in standby cancels a running timer, pushes event code 3 and moves to reserved. Unplug in reserved only sets the function ID to 0.
- R11: When the timeout falls due in a cycle that carries a command, the command is executed and the forced release follows in the next cycle.
- R12: Each event presents class 2 (availability), its code, and the handle and function ID held when it was pushed. `evt_pend_o` is high while the FIFO is not empty, and a pop removes the oldest event.
- R13: A push into a full FIFO is dropped and sets `evt_ovf_o`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command opcode |
| cmd_fid_i | input | FID_W | Function ID of the request |
| cmd_len_i | input | LEN_W | Request length |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_code_o | output | 4 | Response code |
| state_o | output | 3 | Current lifecycle state |
| fid_o | output | FID_W | Held function ID |
| fh_o | output | IDX_W+1 | Function handle: enable bit and index |
| irq_active_i | input | 1 | Interrupt resources are registered |
| xlat_active_i | input | 1 | Translation resources are registered |
| dereg_irq_o | output | 1 | Interrupt deregistration pulse |
| dereg_xlat_o | output | 1 | Translation deregistration pulse |
| evt_pend_o | output | 1 | Event FIFO not empty |
| evt_pop_i | input | 1 | Remove the head event |
| evt_class_o | output | 2 | Head event class |
| evt_code_o | output | 4 | Head event code |
| evt_fh_o | output | IDX_W+1 | Head event function handle |
| evt_fid_o | output | FID_W | Head event function ID |
| evt_ovf_o | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with RELEASE_CYC at 6 and an event FIFO of 4 entries. The short timeout makes the exact cycle of the forced release observable within a few cycles. It also allows a command to be lined up with the expiry cycle, and shows that a cancelled timer never fires. The shallow FIFO fills after four unplug requests, so the fifth exercises the drop and the sticky overflow flag.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [2:0] {
    ST_RESERVED = 3'd0,
    ST_STANDBY  = 3'd1,
    ST_DISABLED = 3'd2,
    ST_ENABLED  = 3'd3,
    ST_BLOCKED  = 3'd4
  } fn_state_e;

  typedef enum logic [2:0] {
    OP_CONFIG   = 3'd0,
    OP_DECONFIG = 3'd1,
    OP_UNPLUG   = 3'd2,
    OP_RESET    = 3'd3,
    OP_ATTACH   = 3'd4,
    OP_ENABLE   = 3'd5,
    OP_BLOCK    = 3'd6,
    OP_NONE     = 3'd7
  } fn_op_e;

  localparam logic [3:0] RSP_NORMAL   = 4'd0;
  localparam logic [3:0] RSP_NO_ACT   = 4'd1;
  localparam logic [3:0] RSP_SHORT    = 4'd2;
  localparam logic [3:0] RSP_UNKNOWN  = 4'd3;
  localparam logic [3:0] RSP_RESERVED = 4'd4;

  localparam logic [1:0] EV_CLASS_AVAIL = 2'd2;
  localparam logic [3:0] EV_DECFG_REQ   = 4'd1;
  localparam logic [3:0] EV_FORCED_DOWN = 4'd2;
  localparam logic [3:0] EV_TO_RESERVED = 4'd3;

  localparam int unsigned MIN_REQ_LEN = 16;
endpackage

// File: rtl/fcs_evt_fifo.sv
module fcs_evt_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             nonempty_o,
  output logic             ovf_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_pop, do_push;

  assign do_pop  = pop_i && (cnt_q != '0);
  assign do_push = push_i && ((cnt_q != FULL_CNT) || do_pop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST_PTR) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == LAST_PTR) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop) cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
      if (push_i && !do_push) ovf_o <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  assign head_o     = mem_q[rd_q];
  assign nonempty_o = (cnt_q != '0);
endmodule

// File: rtl/fcs_release_timer.sv
module fcs_release_timer #(
  parameter int unsigned CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic cancel_i,
  input  logic fire_i,
  output logic due_o
);
  localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (arm_i) begin
      armed_q <= 1'b1;
      cnt_q   <= LOAD;
    end else if (cancel_i || fire_i) begin
      armed_q <= 1'b0;
    end else if (armed_q && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign due_o = armed_q && (cnt_q == '0);
endmodule

// File: rtl/fn_cfg_ctrl.sv
module fn_cfg_ctrl
  import fcs_pkg::*;
#(
  parameter int unsigned FID_W       = 8,
  parameter int unsigned LEN_W       = 16,
  parameter int unsigned IDX_W       = 4,
  parameter int unsigned FN_IDX      = 5,
  parameter int unsigned DEF_FID     = 42,
  parameter int unsigned RELEASE_CYC = 1000,
  parameter int unsigned EVT_DEPTH   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  logic [2:0]         cmd_op_i,
  input  logic [FID_W-1:0]   cmd_fid_i,
  input  logic [LEN_W-1:0]   cmd_len_i,
  output logic               rsp_valid_o,
  output logic [3:0]         rsp_code_o,
  output logic [2:0]         state_o,
  output logic [FID_W-1:0]   fid_o,
  output logic [IDX_W:0]     fh_o,
  input  logic               irq_active_i,
  input  logic               xlat_active_i,
  output logic               dereg_irq_o,
  output logic               dereg_xlat_o,
  output logic               evt_pend_o,
  input  logic               evt_pop_i,
  output logic [1:0]         evt_class_o,
  output logic [3:0]         evt_code_o,
  output logic [IDX_W:0]     evt_fh_o,
  output logic [FID_W-1:0]   evt_fid_o,
  output logic               evt_ovf_o
);
  localparam int unsigned FH_W = IDX_W + 1;
  localparam int unsigned EV_W = 2 + 4 + FH_W + FID_W;
  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_REQ_LEN);

  fn_state_e        state_q, state_d;
  logic [FID_W-1:0] fid_q, fid_d;
  logic             en_q, en_d;
  logic [3:0]       code_d;
  logic             push, arm, cancel, fire, due;
  logic [3:0]       ev_code;
  logic             drop_d;
  logic             active;
  fn_op_e           op;
  logic [EV_W-1:0]  ev_in, ev_head;

  assign op     = fn_op_e'(cmd_op_i);
  assign active = (state_q == ST_DISABLED) || (state_q == ST_ENABLED) ||
                  (state_q == ST_BLOCKED);
  assign fire   = due && !cmd_valid_i;

  always_comb begin
    state_d = state_q;
    fid_d   = fid_q;
    en_d    = en_q;
    code_d  = RSP_NORMAL;
    push    = 1'b0;
    ev_code = EV_DECFG_REQ;
    arm     = 1'b0;
    cancel  = 1'b0;
    drop_d  = 1'b0;
    if (cmd_valid_i) begin
      unique case (op)
        OP_CONFIG, OP_DECONFIG: begin
          if (cmd_len_i < LEN_MIN)      code_d = RSP_SHORT;
          else if (cmd_fid_i != fid_q)  code_d = RSP_UNKNOWN;
          else if (state_q == ST_RESERVED) code_d = RSP_RESERVED;
          else if (op == OP_CONFIG) begin
            if (state_q == ST_STANDBY) state_d = ST_DISABLED;
            else code_d = RSP_NO_ACT;
          end else begin
            if (state_q == ST_STANDBY) code_d = RSP_NO_ACT;
            else begin
              drop_d  = 1'b1;
              en_d    = 1'b0;
              state_d = ST_STANDBY;
            end
          end
        end
        OP_UNPLUG: begin
          if (active) begin
            push = 1'b1;
            arm  = 1'b1;
          end else if (state_q == ST_STANDBY) begin
            cancel  = 1'b1;
            push    = 1'b1;
            ev_code = EV_TO_RESERVED;
            state_d = ST_RESERVED;
          end else begin
            fid_d = '0;
          end
        end
        OP_RESET: begin
          if (active) begin
            en_d    = 1'b0;
            state_d = ST_DISABLED;
          end
        end
        OP_ATTACH: begin
          if (state_q == ST_RESERVED) state_d = ST_STANDBY;
          else code_d = RSP_NO_ACT;
        end
        OP_ENABLE: begin
          if (state_q == ST_DISABLED) begin
            state_d = ST_ENABLED;
            en_d    = 1'b1;
          end else code_d = RSP_NO_ACT;
        end
        OP_BLOCK: begin
          if (state_q == ST_ENABLED) state_d = ST_BLOCKED;
          else code_d = RSP_NO_ACT;
        end
        default: code_d = RSP_NO_ACT;
      endcase
    end else if (fire) begin
      // guest never released the function: force it down
      drop_d  = 1'b1;
      en_d    = 1'b0;
      state_d = ST_STANDBY;
      push    = 1'b1;
      ev_code = EV_FORCED_DOWN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_RESERVED;
      fid_q        <= FID_W'(DEF_FID);
      en_q         <= 1'b0;
      rsp_valid_o  <= 1'b0;
      rsp_code_o   <= RSP_NORMAL;
      dereg_irq_o  <= 1'b0;
      dereg_xlat_o <= 1'b0;
    end else begin
      state_q      <= state_d;
      fid_q        <= fid_d;
      en_q         <= en_d;
      rsp_valid_o  <= cmd_valid_i;
      rsp_code_o   <= cmd_valid_i ? code_d : RSP_NORMAL;
      dereg_irq_o  <= drop_d && irq_active_i;
      dereg_xlat_o <= drop_d && xlat_active_i;
    end
  end

  assign state_o = state_q;
  assign fid_o   = fid_q;
  assign fh_o    = {en_q, IDX_W'(FN_IDX)};
  assign ev_in   = {EV_CLASS_AVAIL, ev_code, fh_o, fid_q};

  fcs_release_timer #(.CYCLES(RELEASE_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (arm),
    .cancel_i (cancel),
    .fire_i   (fire),
    .due_o    (due)
  );

  fcs_evt_fifo #(.WIDTH(EV_W), .DEPTH(EVT_DEPTH)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .data_i     (ev_in),
    .pop_i      (evt_pop_i),
    .head_o     (ev_head),
    .nonempty_o (evt_pend_o),
    .ovf_o      (evt_ovf_o)
  );

  assign {evt_class_o, evt_code_o, evt_fh_o, evt_fid_o} = ev_head;
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned FH_W  = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic [2:0]       cmd_op_i,
  input logic [LEN_W-1:0] cmd_len_i,
  input logic             rsp_valid_o,
  input logic [3:0]       rsp_code_o,
  input logic [2:0]       state_o,
  input logic [FH_W-1:0]  fh_o,
  input logic             irq_active_i,
  input logic             dereg_irq_o,
  input logic             evt_ovf_o
);
  assert_rsp_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> rsp_valid_o);
  assert_rsp_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !rsp_valid_o);
  assert_short_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i <= 3'd1 && cmd_len_i < LEN_W'(16)) |=>
      (rsp_code_o == 4'd2 && $stable(state_o)));
  assert_dereg_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dereg_irq_o |-> $past(irq_active_i));
  assert_enable_entry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3 && $past(state_o) != 3'd3) |-> $past(state_o) == 3'd2);
  assert_en_bit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fh_o[FH_W-1] |-> (state_o == 3'd3 || state_o == 3'd4));
  assert_no_overflow_clear_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_ovf_o |=> evt_ovf_o);
endmodule

bind fn_cfg_ctrl fcs_checker #(.LEN_W(LEN_W), .FH_W(IDX_W + 1)) u_fcs_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_op_i     (cmd_op_i),
  .cmd_len_i    (cmd_len_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_code_o   (rsp_code_o),
  .state_o      (state_o),
  .fh_o         (fh_o),
  .irq_active_i (irq_active_i),
  .dereg_irq_o  (dereg_irq_o),
  .evt_ovf_o    (evt_ovf_o)
);

// File: tb/fn_cfg_ctrl_bench.sv
module fn_cfg_ctrl_bench;
  localparam int unsigned RCYC = 6;
  localparam logic [7:0] FID = 8'h2A;
  localparam logic [4:0] FH_OFF = 5'h05;
  localparam logic [4:0] FH_ON  = 5'h15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [7:0] cmd_fid = '0;
  logic [15:0] cmd_len = '0;
  logic irq_act = 1'b0, xlat_act = 1'b0, pop = 1'b0;
  logic rsp_valid, dereg_irq, dereg_xlat, pend, ovf;
  logic [3:0] rsp_code, ev_code;
  logic [2:0] state;
  logic [7:0] fid, ev_fid;
  logic [4:0] fh, ev_fh;
  logic [1:0] ev_class;
  int nchk = 0, nerr = 0;

  always #5 clk = ~clk;

  fn_cfg_ctrl #(.RELEASE_CYC(RCYC), .EVT_DEPTH(4)) u_fn_cfg_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_fid_i(cmd_fid), .cmd_len_i(cmd_len), .rsp_valid_o(rsp_valid),
    .rsp_code_o(rsp_code), .state_o(state), .fid_o(fid), .fh_o(fh),
    .irq_active_i(irq_act), .xlat_active_i(xlat_act), .dereg_irq_o(dereg_irq),
    .dereg_xlat_o(dereg_xlat), .evt_pend_o(pend), .evt_pop_i(pop),
    .evt_class_o(ev_class), .evt_code_o(ev_code), .evt_fh_o(ev_fh),
    .evt_fid_o(ev_fid), .evt_ovf_o(ovf)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [7:0]  fid;
    logic [15:0] len;
    logic [3:0]  code;
    logic [2:0]  st;
  } vec_t;

  // op: 0 cfg 1 decfg 2 unplug 3 reset 4 attach 5 enable 6 block
  localparam vec_t VECS [16] = '{
    '{3'd0, 8'h2A, 16'd8,  4'd2, 3'd0},  // R3
    '{3'd0, 8'h11, 16'd16, 4'd3, 3'd0},  // R4
    '{3'd0, 8'h2A, 16'd16, 4'd4, 3'd0},  // R5
    '{3'd1, 8'h2A, 16'd16, 4'd4, 3'd0},  // R6
    '{3'd4, 8'h00, 16'd0,  4'd0, 3'd1},  // R7
    '{3'd1, 8'h2A, 16'd16, 4'd1, 3'd1},  // R6
    '{3'd0, 8'h2A, 16'd16, 4'd0, 3'd2},  // R5
    '{3'd0, 8'h2A, 16'd99, 4'd1, 3'd2},  // R5
    '{3'd5, 8'h00, 16'd0,  4'd0, 3'd3},  // R7
    '{3'd6, 8'h00, 16'd0,  4'd0, 3'd4},  // R7
    '{3'd3, 8'h00, 16'd0,  4'd0, 3'd2},  // R8
    '{3'd5, 8'h00, 16'd0,  4'd0, 3'd3},  // R7
    '{3'd1, 8'h2A, 16'd15, 4'd2, 3'd3},  // R3
    '{3'd1, 8'h2A, 16'd16, 4'd0, 3'd1},  // R6
    '{3'd3, 8'h00, 16'd0,  4'd0, 3'd1},  // R8
    '{3'd4, 8'h00, 16'd0,  4'd1, 3'd1}   // R7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [7:0] f, input logic [15:0] l);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_fid = f; cmd_len = l;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic do_pop();
    @(negedge clk);
    pop = 1'b1;
    @(posedge clk); #1;
    pop = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #2_000_000;
    nerr++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #23 rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 state", state, 0);
    check("R1 fid", fid, FID);
    check("R1 fh", fh, FH_OFF);
    check("R1 pend", pend, 0);
    check("R1 ovf", ovf, 0);
    check("R1 strobes", {dereg_irq, dereg_xlat, rsp_valid}, 0);

    foreach (VECS[i]) begin
      cmd(VECS[i].op, VECS[i].fid, VECS[i].len);
      check("R2 rsp_valid", rsp_valid, 1);
      check($sformatf("R2 code vec %0d", i), rsp_code, VECS[i].code);
      check($sformatf("R5 state vec %0d", i), state, VECS[i].st);
    end
    idle(1);
    check("R2 rsp drop", rsp_valid, 0);
    check("R12 no events", pend, 0);

    // R8 reset clears enable bit; R6 dereg strobes
    cmd(0, FID, 16); cmd(5, 0, 0);
    check("R7 enable bit", fh, FH_ON);
    cmd(3, 0, 0);
    check("R8 fh", fh, FH_OFF);
    check("R8 state", state, 2);
    cmd(5, 0, 0);
    irq_act = 1'b1;
    cmd(1, FID, 16);
    check("R6 dereg irq", dereg_irq, 1);
    check("R6 dereg xlat gated", dereg_xlat, 0);
    check("R6 fh", fh, FH_OFF);
    idle(1);
    check("R6 pulse width", dereg_irq, 0);
    irq_act = 1'b0;

    // R9 unplug in enabled, forced release
    cmd(0, FID, 16); cmd(5, 0, 0);
    cmd(2, 0, 0);
    check("R9 rsp", rsp_code, 0);
    check("R12 pend", pend, 1);
    check("R12 class", ev_class, 2);
    check("R9 ev code", ev_code, 1);
    check("R12 ev fh", ev_fh, FH_ON);
    check("R12 ev fid", ev_fid, FID);
    irq_act = 1'b1; xlat_act = 1'b1;
    idle(RCYC - 1);
    check("R9 before expiry", state, 3);
    idle(1);
    check("R9 after expiry", state, 1);
    check("R9 dereg", {dereg_irq, dereg_xlat}, 2'b11);
    check("R9 fh", fh, FH_OFF);
    irq_act = 1'b0; xlat_act = 1'b0;
    do_pop();
    check("R12 second pend", pend, 1);
    check("R9 ev2 code", ev_code, 2);
    check("R9 ev2 fh", ev_fh, FH_ON);
    do_pop();
    check("R12 empty", pend, 0);

    // R10 standby unplug cancels timer
    cmd(0, FID, 16); cmd(5, 0, 0); cmd(2, 0, 0);
    cmd(1, FID, 16);
    cmd(2, 0, 0);
    check("R10 state", state, 0);
    idle(RCYC + 2);
    check("R10 timer cancelled", state, 0);
    do_pop();
    check("R10 ev code", ev_code, 3);
    check("R10 ev fh", ev_fh, FH_OFF);
    do_pop();
    check("R10 no forced event", pend, 0);

    // R10 unplug in reserved clears fid
    cmd(2, 0, 0);
    check("R10 fid", fid, 0);
    check("R10 stays reserved", state, 0);
    cmd(0, FID, 16);
    check("R4 old fid", rsp_code, 3);
    cmd(0, 8'h00, 16);
    check("R5 reserved", rsp_code, 4);

    // R11 command in expiry cycle
    cmd(4, 0, 0); cmd(0, 0, 16); cmd(5, 0, 0); cmd(2, 0, 0);
    idle(RCYC - 1);
    cmd(6, 0, 0);
    check("R11 cmd wins", state, 4);
    check("R11 rsp", rsp_code, 0);
    idle(1);
    check("R11 deferred release", state, 1);
    do_pop(); do_pop();
    check("R11 two events", pend, 0);

    // R13 overflow
    cmd(0, 0, 16); cmd(5, 0, 0);
    for (int k = 0; k < 4; k++) cmd(2, 0, 0);
    check("R13 full no ovf", ovf, 0);
    cmd(2, 0, 0);
    check("R13 ovf", ovf, 1);
    for (int k = 0; k < 4; k++) begin
      check("R13 kept code", ev_code, 1);
      do_pop();
    end
    check("R13 dropped", pend, 0);
    check("R13 sticky", ovf, 1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule